// File: doc/BRIEF.md
# Banked Register-File Operand Collector

This block gathers the three source operands of a multiply-add instruction (result = B*C + D) from a register file. The file is split into four banks, and each bank can serve one read per cycle. An instruction arrives as three 6-bit register indices through a valid/ready handshake. The block works out which bank holds each index and merges fields that name the same register. It then spreads the reads over as many cycles as the most crowded bank needs. When every operand is latched, the three values appear together for one cycle, along with the conflict degree (1, 2 or 3).

A separate write port loads register contents through the same bank mapping. While a collection takes more than one cycle, the block refuses new instructions. It raises ready again in the final collection cycle, so instructions without conflicts can be accepted on every cycle.

Top module: `opnd_collector`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: Register index i lives in bank {i[0], i[2]}, at entry {i[5:3], i[1]} of that bank. Each of the four banks has 16 entries, so all 64 indices have separate storage.
- R3: A write with wr_en=1 stores wr_data at wr_idx, and any later read of that index returns the stored value.
- R4: When a write and a bank read of the same register happen in the same cycle, the read returns the value held before the write.
- R5: If the distinct source registers all sit in different banks, conflict_degree is 1. out_valid rises in the cycle right after the accepting edge, and in_ready stays 1, so a new instruction can be accepted on every cycle.
- R6: If the most crowded bank holds two distinct source registers, conflict_degree is 2 and out_valid rises two cycles after the accepting edge.
- R7: If three distinct source registers share one bank, conflict_degree is 3 and out_valid rises three cycles after the accepting edge.
- R8: Source fields that name the same register are read once. They add nothing to the conflict degree, and each of them receives that register's value.
- R9: During a collection, in_ready is 0 in every cycle except the last one. An instruction held on the inputs meanwhile is accepted only once in_ready returns to 1, and the collection in progress is not disturbed.
- R10: op_b, op_c and op_d carry the contents of the registers named by src_b, src_c and src_d respectively. out_valid is high for exactly one cycle per accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take an instruction this cycle |
| src_b | input | 6 | Index of multiplicand register B |
| src_c | input | 6 | Index of multiplier register C |
| src_d | input | 6 | Index of addend register D |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Register index to write |
| wr_data | input | DATA_W | Value to write |
| out_valid | output | 1 | Operands valid (one-cycle pulse) |
| op_b | output | DATA_W | Value of register B |
| op_c | output | DATA_W | Value of register C |
| op_d | output | DATA_W | Value of register D |
| conflict_degree | output | 2 | Read cycles used: 1, 2 or 3 |

## Verification
Two situations are hard to reach from the ports. The first is a write that lands on a register in the very cycle its bank is being read. The stimulus reaches it by issuing a single-cycle instruction and driving the write in the cycle after the accepting edge. The second is an instruction that waits on the inputs while ready is low. The bench presents a new instruction during a three-cycle collection, checks in_ready in each of those cycles, and confirms both results and their timing. Index sets with merged duplicates, whose banks would look conflicted if duplicates were counted, show that the degree counts distinct registers only.

// File: rtl/opc_pkg.sv
package opc_pkg;
  localparam int OPC_IDX_W  = 6;
  localparam int OPC_BANKS  = 4;
  localparam int OPC_BANK_W = $clog2(OPC_BANKS);
  localparam int OPC_ENT_W  = OPC_IDX_W - OPC_BANK_W;
  localparam int OPC_SRCS   = 3;
  localparam int OPC_SLOT_W = 2;

  typedef logic [OPC_IDX_W-1:0] regIdx_t;

  // Bank select: parity bit then half-of-octet bit.
  function automatic logic [OPC_BANK_W-1:0] bankOf(regIdx_t i);
    return {i[0], i[2]};
  endfunction

  function automatic logic [OPC_ENT_W-1:0] entryOf(regIdx_t i);
    return {i[5:3], i[1]};
  endfunction

  typedef struct packed {
    logic [OPC_BANKS-1:0]                 rdEn;
    logic [OPC_BANKS-1:0][OPC_ENT_W-1:0]  rdEntry;
    logic [OPC_SRCS-1:0]                  capture;
    logic [OPC_SRCS-1:0][OPC_BANK_W-1:0]  srcBank;
  } opcStrobe_t;
endpackage

// File: rtl/opc_bank.sv
module opc_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ENT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ENT_W-1:0]  wrEntry,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ENT_W-1:0]  rdEntry,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Read sees the array before this edge's write: old value on collision.
  assign rdData = mem[rdEntry];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrEntry] <= wrData;
  end
endmodule

// File: rtl/opc_ctrl.sv
module opc_ctrl
  import opc_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 inValid,
  input  logic [OPC_SRCS-1:0][OPC_IDX_W-1:0]   inIdx,
  output logic                                 inReady,
  output logic                                 outValid,
  output logic [1:0]                           degree,
  output opcStrobe_t                           strobe
);
  logic                                 busy;
  logic [OPC_SLOT_W-1:0]                cnt;
  logic [1:0]                           degReg;
  logic [OPC_SRCS-1:0][OPC_IDX_W-1:0]   idxR;
  logic [OPC_SRCS-1:0][OPC_SLOT_W-1:0]  slotR;
  logic [OPC_SRCS-1:0][OPC_SLOT_W-1:0]  newSlot;
  logic [1:0]                           newDeg;
  logic                                 lastCyc;
  logic                                 fire;

  // Slot = rank of a register among distinct earlier registers in its bank.
  always_comb begin
    logic [OPC_SRCS-1:0]   firstOcc;
    logic [OPC_SLOT_W-1:0] s [OPC_SRCS];
    logic [OPC_SLOT_W-1:0] mx;
    for (int o = 0; o < OPC_SRCS; o++) begin
      firstOcc[o] = 1'b1;
      for (int p = 0; p < o; p++)
        if (inIdx[p] == inIdx[o]) firstOcc[o] = 1'b0;
    end
    for (int o = 0; o < OPC_SRCS; o++) begin
      s[o] = '0;
      if (firstOcc[o]) begin
        for (int p = 0; p < o; p++)
          if (firstOcc[p] && (bankOf(inIdx[p]) == bankOf(inIdx[o])))
            s[o] = s[o] + OPC_SLOT_W'(1);
      end else begin
        for (int p = o - 1; p >= 0; p--)
          if (inIdx[p] == inIdx[o]) s[o] = s[p];
      end
    end
    mx = '0;
    for (int o = 0; o < OPC_SRCS; o++) begin
      newSlot[o] = s[o];
      if (s[o] > mx) mx = s[o];
    end
    newDeg = mx + 2'd1;
  end

  assign lastCyc = busy && (cnt == OPC_SLOT_W'(degReg - 2'd1));
  assign inReady = !busy || lastCyc;
  assign fire    = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      degReg   <= 2'd1;
      idxR     <= '0;
      slotR    <= '0;
      outValid <= 1'b0;
      degree   <= 2'd0;
    end else begin
      outValid <= lastCyc;
      if (lastCyc) degree <= degReg;
      if (fire) begin
        busy   <= 1'b1;
        cnt    <= '0;
        idxR   <= inIdx;
        slotR  <= newSlot;
        degReg <= newDeg;
      end else if (lastCyc) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + OPC_SLOT_W'(1);
      end
    end
  end

  // Per bank, the oldest source due in this cycle drives the read port.
  always_comb begin
    strobe = '0;
    for (int o = 0; o < OPC_SRCS; o++) begin
      strobe.capture[o] = busy && (slotR[o] == cnt);
      strobe.srcBank[o] = bankOf(idxR[o]);
    end
    for (int b = 0; b < OPC_BANKS; b++) begin
      for (int o = OPC_SRCS - 1; o >= 0; o--) begin
        if (busy && (slotR[o] == cnt) && (bankOf(idxR[o]) == OPC_BANK_W'(b))) begin
          strobe.rdEn[b]    = 1'b1;
          strobe.rdEntry[b] = entryOf(idxR[o]);
        end
      end
    end
  end

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !busy) |=> !outValid);

  assert_degree_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (degree != 2'd0));

  assert_hold_during_collect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lastCyc) |=> ($stable(idxR) && busy));

  assert_accept_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (busy && cnt == '0));
endmodule

// File: rtl/opc_datapath.sv
module opc_datapath
  import opc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  opcStrobe_t                        strobe,
  input  logic                              wrEn,
  input  logic [OPC_IDX_W-1:0]              wrIdx,
  input  logic [DATA_W-1:0]                 wrData,
  output logic [OPC_SRCS-1:0][DATA_W-1:0]   operands
);
  localparam int DEPTH = 1 << OPC_ENT_W;

  logic [DATA_W-1:0] rdData [OPC_BANKS];

  for (genvar b = 0; b < OPC_BANKS; b++) begin : g_bank
    logic bankWr;
    assign bankWr = wrEn && (bankOf(wrIdx) == OPC_BANK_W'(b));
    opc_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .wrEn    (bankWr),
      .wrEntry (entryOf(wrIdx)),
      .wrData  (wrData),
      .rdEntry (strobe.rdEntry[b]),
      .rdData  (rdData[b])
    );
  end

  for (genvar o = 0; o < OPC_SRCS; o++) begin : g_opnd
    always_ff @(posedge clk) begin
      if (!rst_n) operands[o] <= '0;
      else if (strobe.capture[o]) operands[o] <= rdData[strobe.srcBank[o]];
    end

    assert_bank_served_R2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.capture[o] |-> strobe.rdEn[strobe.srcBank[o]]);
  end
endmodule

// File: rtl/opnd_collector.sv
module opnd_collector
  import opc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [OPC_IDX_W-1:0]  src_b,
  input  logic [OPC_IDX_W-1:0]  src_c,
  input  logic [OPC_IDX_W-1:0]  src_d,
  input  logic                  wr_en,
  input  logic [OPC_IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     op_b,
  output logic [DATA_W-1:0]     op_c,
  output logic [DATA_W-1:0]     op_d,
  output logic [1:0]            conflict_degree
);
  opcStrobe_t                           strobe;
  logic [OPC_SRCS-1:0][DATA_W-1:0]      operands;
  logic [OPC_SRCS-1:0][OPC_IDX_W-1:0]   srcIdx;

  assign srcIdx = {src_d, src_c, src_b};

  opc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (in_valid),
    .inIdx    (srcIdx),
    .inReady  (in_ready),
    .outValid (out_valid),
    .degree   (conflict_degree),
    .strobe   (strobe)
  );

  opc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wrEn     (wr_en),
    .wrIdx    (wr_idx),
    .wrData   (wr_data),
    .operands (operands)
  );

  assign op_b = operands[0];
  assign op_c = operands[1];
  assign op_d = operands[2];
endmodule

// File: tb/opnd_collector_bench.sv
module opnd_collector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  src_b = '0, src_c = '0, src_d = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        out_valid;
  logic [31:0] op_b, op_c, op_d;
  logic [1:0]  conflict_degree;

  opnd_collector u_opnd_collector (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] refMem [64];

  typedef struct {
    logic [31:0] vb, vc, vd;
    int deg, at;
    string tag;
  } expItem_t;
  expItem_t sb [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bankOfRef(input logic [5:0] i);
    return (i[0] ? 2 : 0) + (i[2] ? 1 : 0);
  endfunction

  // Degree: most distinct registers in any one bank.
  function automatic int degRef(input logic [5:0] b, input logic [5:0] c, input logic [5:0] d);
    int n [4];
    int mx;
    for (int k = 0; k < 4; k++) n[k] = 0;
    n[bankOfRef(b)]++;
    if (c != b) n[bankOfRef(c)]++;
    if (d != b && d != c) n[bankOfRef(d)]++;
    mx = 0;
    for (int k = 0; k < 4; k++) if (n[k] > mx) mx = n[k];
    return mx;
  endfunction

  task automatic pushExp(input logic [5:0] b, input logic [5:0] c, input logic [5:0] d, input int acceptEdge, input string tag);
    expItem_t e;
    e.vb = refMem[b]; e.vc = refMem[c]; e.vd = refMem[d];
    e.deg = degRef(b, c, d);
    e.at = acceptEdge + e.deg;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic issue(input logic [5:0] b, input logic [5:0] c, input logic [5:0] d, input string tag);
    @(negedge clk);
    in_valid = 1'b1; src_b = b; src_c = c; src_d = d;
    while (!in_ready) @(negedge clk);
    pushExp(b, c, d, cyc + 1, tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [5:0] idx, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    refMem[idx] = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: compare each result against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected out_valid", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = sb.pop_front();
        check(op_b == e.vb, {e.tag, " R10 op_b"}, op_b, e.vb);
        check(op_c == e.vc, {e.tag, " R10 op_c"}, op_c, e.vc);
        check(op_d == e.vd, {e.tag, " R10 op_d"}, op_d, e.vd);
        check(int'(conflict_degree) == e.deg, {e.tag, " degree"}, 32'(conflict_degree), 32'(e.deg));
        check(cyc == e.at, {e.tag, " latency"}, 32'(cyc), 32'(e.at));
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);

    // R3: load every register through the write port.
    for (int i = 0; i < 64; i++) regWrite(6'(i), 32'h1000_0000 + 32'(i) * 32'h0101_0107);

    // R5: distinct banks, back to back.
    issue(0, 4, 1, "R5 a");
    issue(5, 9, 12, "R5 b");
    issue(63, 6, 33, "R5 c");
    idle(4);

    // R6 / R2: two distinct in one bank; 63 and 61 share bank 3.
    issue(0, 2, 4, "R6 a");
    issue(63, 61, 59, "R6 R2 b");
    idle(5);

    // R7 / R2: three in a bank, including high entries.
    issue(0, 8, 40, "R7 R2 a");
    issue(5, 7, 13, "R7 b");
    idle(6);

    // R8: duplicates merged.
    issue(6, 6, 6, "R8 all same");
    issue(1, 3, 3, "R8 pair");
    issue(10, 2, 10, "R8 bd");
    issue(0, 0, 8, "R8 bc");
    idle(5);

    // R3: overwrite then read.
    regWrite(10, 32'hDEAD_BEEF);
    issue(10, 4, 1, "R3 overwrite");
    idle(4);

    // R4: write lands in the read cycle of a one-cycle collection.
    issue(0, 4, 1, "R4 old");
    @(negedge clk);
    in_valid = 1'b0;
    wr_en = 1'b1; wr_idx = 6'd0; wr_data = 32'hCAFE_0000;
    @(negedge clk);
    wr_en = 1'b0;
    refMem[0] = 32'hCAFE_0000;
    issue(0, 4, 1, "R4 new");
    idle(4);

    // R9: stall during a three-cycle collection with a waiting instruction.
    issue(0, 2, 8, "R9 first");
    @(negedge clk);
    check(in_ready == 1'b0, "R9 ready cycle1", 32'(in_ready), 32'd0);
    src_b = 5; src_c = 9; src_d = 12;
    @(negedge clk);
    check(in_ready == 1'b0, "R9 ready cycle2", 32'(in_ready), 32'd0);
    @(negedge clk);
    check(in_ready == 1'b1, "R9 ready last", 32'(in_ready), 32'd1);
    pushExp(5, 9, 12, cyc + 1, "R9 second");
    idle(6);

    // Mixed stream of computed patterns.
    for (int k = 0; k < 40; k++)
      issue(6'((k * 7) % 64), 6'((k * 13 + 5) % 64), 6'((k * 29 + 11) % 64), "R10 mix");
    idle(8);

    check(sb.size() == 0, "R10 all results seen", 32'(sb.size()), 32'd0);
    finishRun();
  end
endmodule